// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

A sequential engine that picks the settings for a clock divider whose predivide stage can divide by 2, 2.5 or 3 and whose second stage divides by an integer. The engine receives a target output rate and the rates of three candidate references. The references are indexed 0 for the first PLL, 1 for the second PLL and 2 for the crystal. It returns the reference to use, the predivide code, the integer divisor and the rate that these settings actually produce.

A one-cycle `start` pulse captures the target and the three reference rates. The engine first limits the target to a quarter of the fastest reference. It then tries all nine combinations of reference and predivide code. Each division goes through one shared, multi-cycle restoring divider. The rate arithmetic uses doubled reference rates, so the half-step predivider stays in integer arithmetic. The predivide codes 4, 5 and 6 stand for division by 2, 2.5 and 3. A one-cycle `done` pulse marks the result, and `fail` reports that no combination gave a usable divisor.

Top module: `clkdiv_search`

## Requirements
- R1: The target used in the search is min(`target`, floor(max(`ref_a`,`ref_b`,`ref_x`)/4)), computed from the values present on the cycle `start` is accepted.
- R2: For each reference s (0=`ref_a`, 1=`ref_b`, 2=`ref_x`) and each predivide code p in {4,5,6}, the divisor is floor(2·ref_s / (T·p)), where T is the limited target. `sel_pre` reports p as the raw value 4, 5 or 6.
- R3: A combination whose divisor is below 2 or above 127 is discarded. A reported divisor is always within 2..127.
- R4: The reported rate `rate_out` equals floor(2·ref_s / (p·divisor)) for the reported s, p and divisor.
- R5: The reported combination has the smallest |rate − T| of all kept combinations. On a tie, the earliest is kept in the order: reference 0, 1, 2, with p ascending within each reference.
- R6: When no combination is kept (this includes T = 0), `done` comes with `fail`=1, and `sel_src`, `sel_pre`, `sel_div` and `rate_out` are all 0.
- R7: A `start` pulse while `busy` is 1 has no effect: the running search and its result are unchanged.
- R8: `busy` is 1 from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse, it comes with `busy`=0, and the result outputs change only on the cycle `done` is 1.
- R9: After reset, `busy`, `done` and `fail` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| target | input | RATE_W | Requested output rate |
| ref_a | input | RATE_W | Rate of reference 0 (first PLL) |
| ref_b | input | RATE_W | Rate of reference 1 (second PLL) |
| ref_x | input | RATE_W | Rate of reference 2 (crystal) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| fail | output | 1 | No combination passed the divisor range |
| sel_src | output | 2 | Chosen reference index |
| sel_pre | output | 3 | Chosen predivide code (4, 5 or 6) |
| sel_div | output | DIV_W | Chosen integer divisor |
| rate_out | output | RATE_W | Rate produced by the chosen setting |

## Verification
Typical references with a video-like target check the main search; a case where only the second PLL can reach the target exactly checks that the choice is not biased toward reference 0. A target above the quarter-rate limit checks the clamp. Identical references check the tie rule. Reference rates that put the code-4 divisor at exactly 127 and then 128 show the upper bound working, and they also give a tie between codes 5 and 6. A tiny target and a zero target force failure. A second start issued mid-search, carrying a different target, checks that the request is ignored. A series of pseudo-random settings is then compared against a behavioural model, with the result outputs checked for stability on every clock between done pulses.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

    localparam int NUM_SRC = 3;
    localparam int NUM_PRE = 3;
    localparam logic [2:0] PRE_FIRST = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_Q_GO,
        ST_Q_WAIT,
        ST_R_GO,
        ST_R_WAIT,
        ST_NEXT
    } state_e;

    // Predivide code for a loop index: 4 -> /2, 5 -> /2.5, 6 -> /3.
    function automatic logic [2:0] pre_code(input logic [1:0] idx);
        return PRE_FIRST + {1'b0, idx};
    endfunction

    function automatic logic [1:0] last_idx(input int n);
        return 2'(n - 1);
    endfunction

endpackage

// File: rtl/rdiv_restoring.sv
module rdiv_restoring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {r_r, q_r[W-1]} - {1'b0, d_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run) begin
                q_r <= dividend;
                r_r <= '0;
                d_r <= divisor;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                q_r <= {q_r[W-2:0], ~trial[W]};
                r_r <= trial[W] ? {r_r[W-2:0], q_r[W-1]} : trial[W-1:0];
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

    // R4: the remainder left at completion is below the divisor
    assert_rem_below_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (r_r < d_r));

    // R2: the search never launches a division by zero
    assert_nonzero_den_R2: assert property (@(posedge clk) disable iff (rst)
        (go && !run) |-> (divisor != '0));

endmodule

// File: rtl/best_keep.sv
module best_keep #(
    parameter int RATE_W = 31,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              offer,
    input  logic [1:0]        c_src,
    input  logic [2:0]        c_pre,
    input  logic [DIV_W-1:0]  c_div,
    input  logic [RATE_W-1:0] c_rate,
    input  logic [RATE_W-1:0] c_err,
    output logic              have,
    output logic [1:0]        b_src,
    output logic [2:0]        b_pre,
    output logic [DIV_W-1:0]  b_div,
    output logic [RATE_W-1:0] b_rate
);
    typedef struct packed {
        logic [1:0]        src;
        logic [2:0]        pre;
        logic [DIV_W-1:0]  dv;
        logic [RATE_W-1:0] rate;
        logic [RATE_W-1:0] err;
    } cand_t;

    cand_t best;
    logic  take;

    // strict less-than keeps the earliest candidate on a tie
    assign take = offer && (!have || (c_err < best.err));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best <= '0;
            have <= 1'b0;
        end else if (take) begin
            best <= '{src: c_src, pre: c_pre, dv: c_div, rate: c_rate, err: c_err};
            have <= 1'b1;
        end
    end

    assign b_src  = best.src;
    assign b_pre  = best.pre;
    assign b_div  = best.dv;
    assign b_rate = best.rate;

    // R5: once a best exists, its error never grows within a search
    assert_err_nonrise_R5: assert property (@(posedge clk) disable iff (rst)
        (have && $past(have)) |-> (best.err <= $past(best.err)));

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_search_pkg::*;
#(
    parameter int RATE_W  = 31,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 127,
    localparam int DIV_W  = $clog2(DIV_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] target,
    input  logic [RATE_W-1:0] ref_a,
    input  logic [RATE_W-1:0] ref_b,
    input  logic [RATE_W-1:0] ref_x,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        sel_src,
    output logic [2:0]        sel_pre,
    output logic [DIV_W-1:0]  sel_div,
    output logic [RATE_W-1:0] rate_out
);
    localparam int NUM_W = RATE_W + 1;
    localparam logic [1:0] LAST_SRC = last_idx(NUM_SRC);
    localparam logic [1:0] LAST_PRE = last_idx(NUM_PRE);

    state_e            st;
    logic [RATE_W-1:0] ref0_q, ref1_q, ref2_q, tgt_q, cur_ref;
    logic [1:0]        sidx, pidx;
    logic [2:0]        pre;
    logic [DIV_W-1:0]  cur_div;

    logic [RATE_W-1:0] mx_ab, mx_all, lim, tgt_in;
    logic [NUM_W-1:0]  dvd, den, quot, rem;
    logic              dv_go, dv_done, in_range;
    logic [RATE_W-1:0] cand_rate, cand_err;
    logic              offer, clr, have;
    logic [1:0]        b_src;
    logic [2:0]        b_pre;
    logic [DIV_W-1:0]  b_div;
    logic [RATE_W-1:0] b_rate;

    // target limit: a quarter of the fastest reference
    assign mx_ab  = (ref_a > ref_b) ? ref_a : ref_b;
    assign mx_all = (mx_ab > ref_x) ? mx_ab : ref_x;
    assign lim    = mx_all >> 2;
    assign tgt_in = (target > lim) ? lim : target;

    always_comb begin
        unique case (sidx)
            2'd0:    cur_ref = ref0_q;
            2'd1:    cur_ref = ref1_q;
            default: cur_ref = ref2_q;
        endcase
    end

    assign pre   = pre_code(pidx);
    assign dvd   = {cur_ref, 1'b0};
    assign den   = (st == ST_R_GO) ? NUM_W'(pre) * NUM_W'(cur_div)
                                   : NUM_W'(tgt_q) * NUM_W'(pre);
    assign dv_go = ((st == ST_Q_GO) && (tgt_q != '0)) || (st == ST_R_GO);

    rdiv_restoring #(.W(NUM_W)) u_div (
        .clk(clk), .rst(rst), .go(dv_go), .dividend(dvd), .divisor(den),
        .done(dv_done), .quot(quot), .rem(rem)
    );

    assign in_range  = (quot >= NUM_W'(DIV_MIN)) && (quot <= NUM_W'(DIV_MAX));
    assign cand_rate = quot[RATE_W-1:0];
    assign cand_err  = (cand_rate > tgt_q) ? cand_rate - tgt_q : tgt_q - cand_rate;
    assign offer     = (st == ST_R_WAIT) && dv_done;
    assign clr       = (st == ST_IDLE) && start;

    best_keep #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_best (
        .clk(clk), .rst(rst), .clr(clr), .offer(offer),
        .c_src(sidx), .c_pre(pre), .c_div(cur_div), .c_rate(cand_rate), .c_err(cand_err),
        .have(have), .b_src(b_src), .b_pre(b_pre), .b_div(b_div), .b_rate(b_rate)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ref0_q   <= '0;
            ref1_q   <= '0;
            ref2_q   <= '0;
            tgt_q    <= '0;
            sidx     <= '0;
            pidx     <= '0;
            cur_div  <= '0;
            done     <= 1'b0;
            fail     <= 1'b0;
            sel_src  <= '0;
            sel_pre  <= '0;
            sel_div  <= '0;
            rate_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    ref0_q <= ref_a;
                    ref1_q <= ref_b;
                    ref2_q <= ref_x;
                    tgt_q  <= tgt_in;
                    sidx   <= '0;
                    pidx   <= '0;
                    st     <= ST_Q_GO;
                end
                ST_Q_GO:   st <= (tgt_q == '0) ? ST_NEXT : ST_Q_WAIT;
                ST_Q_WAIT: if (dv_done) begin
                    cur_div <= quot[DIV_W-1:0];
                    st      <= in_range ? ST_R_GO : ST_NEXT;
                end
                ST_R_GO:   st <= ST_R_WAIT;
                ST_R_WAIT: if (dv_done) st <= ST_NEXT;
                ST_NEXT: begin
                    if (pidx == LAST_PRE) begin
                        pidx <= '0;
                        if (sidx == LAST_SRC) begin
                            st       <= ST_IDLE;
                            done     <= 1'b1;
                            fail     <= !have;
                            sel_src  <= have ? b_src  : '0;
                            sel_pre  <= have ? b_pre  : '0;
                            sel_div  <= have ? b_div  : '0;
                            rate_out <= have ? b_rate : '0;
                        end else begin
                            sidx <= sidx + 2'd1;
                            st   <= ST_Q_GO;
                        end
                    end else begin
                        pidx <= pidx + 2'd1;
                        st   <= ST_Q_GO;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: result outputs only move on a done cycle
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({fail, sel_src, sel_pre, sel_div, rate_out}));

    // R3: a reported divisor is in range
    assert_div_range_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ((sel_div >= DIV_W'(DIV_MIN)) && (sel_div <= DIV_W'(DIV_MAX))));

    // R2: reported predivide code and source are legal
    assert_pre_code_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ((sel_pre >= 3'd4) && (sel_pre <= 3'd6) && (sel_src <= 2'd2)));

    // R6: failure clears the result fields
    assert_fail_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> ((sel_div == '0) && (rate_out == '0) && (sel_pre == '0)));

    // R7: a start during a search neither ends nor restarts it early
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

endmodule

// File: tb/clkdiv_search_bench.sv
module clkdiv_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 31;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [RW-1:0] target = '0, ref_a = '0, ref_b = '0, ref_x = '0;
    logic          busy, done, fail;
    logic [1:0]    sel_src;
    logic [2:0]    sel_pre;
    logic [DW-1:0] sel_div;
    logic [RW-1:0] rate_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // expected result of the pending search, and values held since the last done
    bit     pending = 0;
    string  tag = "R9";
    bit     e_fail = 0, h_fail = 0;
    int     e_src = 0, e_pre = 0, e_div = 0, h_src = 0, h_pre = 0, h_div = 0;
    longint e_rate = 0, h_rate = 0;
    int     wait_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_search u_clkdiv_search (
        .clk(clk), .rst(rst), .start(start), .target(target),
        .ref_a(ref_a), .ref_b(ref_b), .ref_x(ref_x),
        .busy(busy), .done(done), .fail(fail),
        .sel_src(sel_src), .sel_pre(sel_pre), .sel_div(sel_div), .rate_out(rate_out)
    );

    // behavioural model of the search (R1..R6)
    task automatic model(input longint a, input longint b, input longint x, input longint t_in);
        longint refs[3];
        longint mx, t, best;
        bit ok;
        refs[0] = a; refs[1] = b; refs[2] = x;
        mx = a; if (b > mx) mx = b; if (x > mx) mx = x;
        t = t_in; if (t > mx / 4) t = mx / 4;        // R1
        ok = 0; best = 0;
        e_src = 0; e_pre = 0; e_div = 0; e_rate = 0;
        for (int s = 0; s < 3; s++) begin
            for (int p = 4; p <= 6; p++) begin
                longint q, r, e;
                if (t == 0) continue;
                q = (2 * refs[s]) / (t * p);          // R2
                if (q < 2 || q > 127) continue;       // R3
                r = (2 * refs[s]) / (p * q);          // R4
                e = (r > t) ? r - t : t - r;
                if (!ok || e < best) begin            // R5 tie keeps earlier
                    ok = 1; best = e;
                    e_src = s; e_pre = p; e_div = int'(q); e_rate = r;
                end
            end
        end
        e_fail = !ok;                                 // R6
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                chk(pending ? tag : "R8", "done expected", longint'(pending), 1);
                chk("R8", "busy at done", longint'(busy), 0);
                chk(tag, "fail", longint'(fail), longint'(e_fail));
                chk(tag, "sel_src", longint'(sel_src), e_src);
                chk(tag, "sel_pre", longint'(sel_pre), e_pre);
                chk(tag, "sel_div", longint'(sel_div), e_div);
                chk(tag, "rate_out", longint'(rate_out), e_rate);
                h_fail = e_fail; h_src = e_src; h_pre = e_pre; h_div = e_div; h_rate = e_rate;
                pending = 0;
                wait_cyc = 0;
            end else begin
                // R8 / R9: outputs hold between done pulses (zero after reset)
                chk("R8", "hold fail", longint'(fail), longint'(h_fail));
                chk("R8", "hold sel_src", longint'(sel_src), h_src);
                chk("R8", "hold sel_pre", longint'(sel_pre), h_pre);
                chk("R8", "hold sel_div", longint'(sel_div), h_div);
                chk("R8", "hold rate_out", longint'(rate_out), h_rate);
                if (pending) begin
                    wait_cyc++;
                    if (wait_cyc == 5000) chk("R8", "search completes", 0, 1);
                end
            end
        end
    end

    task automatic launch(input string req, input longint a, input longint b,
                          input longint x, input longint t);
        wait (!pending);
        @(negedge clk); #1;
        ref_a = RW'(a); ref_b = RW'(b); ref_x = RW'(x); target = RW'(t);
        start = 1'b1;
        model(a, b, x, t);
        tag = req;
        pending = 1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R8", "busy after start", longint'(busy), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R9: reset state
        chk("R9", "busy after reset", longint'(busy), 0);
        chk("R9", "done after reset", longint'(done), 0);
        chk("R9", "fail after reset", longint'(fail), 0);
        chk("R9", "rate_out after reset", longint'(rate_out), 0);

        launch("R2", 368640000, 240000000, 14745600, 25175000);  // typical search
        launch("R4", 1000000, 300000000, 14745600, 12000000);    // second PLL exact
        launch("R1", 368640000, 240000000, 14745600, 2000000000);// above quarter limit
        launch("R5", 100000000, 100000000, 100000000, 10000000); // identical refs: tie
        launch("R3", 254000000, 254000000, 254000000, 1000000);  // divisor exactly 127
        launch("R3", 256000000, 256000000, 256000000, 1000000);  // 128 rejected, 5/6 tie
        launch("R6", 100000000, 100000000, 100000000, 100000);   // all divisors too big
        launch("R6", 100000000, 50000000, 14745600, 0);          // zero target

        // R7: a second start mid-search with another target is ignored
        launch("R7", 368640000, 240000000, 14745600, 31500000);
        repeat (40) @(negedge clk);
        #1;
        target = RW'(5000000); ref_a = RW'(1000); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R7", "still busy after ignored start", longint'(busy), 1);

        seed = 32'h1234_5678;
        for (int i = 0; i < 14; i++) begin
            longint a, b, x, t;
            seed = seed * 32'd1103515245 + 32'd12345; a = 10000000 + longint'(seed % 400000000);
            seed = seed * 32'd1103515245 + 32'd12345; b = 10000000 + longint'(seed % 400000000);
            seed = seed * 32'd1103515245 + 32'd12345; x = 1000000 + longint'(seed % 50000000);
            seed = seed * 32'd1103515245 + 32'd12345; t = 100000 + longint'(seed % 60000000);
            launch("R5", a, b, x, t);
        end
        wait (!pending);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule